// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the purely combinational arithmetic and logic stage of a 32-bit RISC-style execute pipe. Each cycle it receives a 4-bit operation code, a set-flags bit, a first operand read from a register, and a second operand that an upstream shifter has already shifted or formed from an immediate. It also receives the current N/Z/C/V condition flags and the carry-out produced by that shifter. From these it produces the data result, a write enable for the destination register, and the next value of the four flags.

It covers moves, add and subtract forms that chain a carry, reverse subtraction, bitwise logic including bit clear, and four compare-style operations that only change flags. Subtraction reports carry as "no borrow", and the borrow-consuming forms use the inverted incoming carry. Instruction decode supplies the opcode from instruction bits 24:21 and the set-flags bit from bit 20. The register file, the shifter, the multiplier and condition evaluation all sit outside this block.

Top module: `dp_alu`

## Requirements
- R1: Arithmetic codes compute: 4 add A+B, 5 add-with-carry A+B+C, 2 subtract A-B, 6 subtract-with-carry A-B-!C, 3 reverse subtract B-A, 7 reverse subtract-with-carry B-A-!C, with C being bit 1 of `flags_in`, all modulo 2^32.
- R2: Logic codes compute: 0 A AND B, 1 A XOR B, 12 A OR B, 14 A AND NOT B.
- R3: Code 13 outputs B unchanged and code 15 outputs NOT B.
- R4: Codes 8 (A AND B), 9 (A XOR B), 10 (A-B) and 11 (A+B) deassert `result_we` and update all four flags whatever the value of `set_flags`.
- R5: Every code outside 8 to 11 asserts `result_we`.
- R6: A code outside 8 to 11 with `set_flags` low returns `flags_out` equal to `flags_in`.
- R7: Whenever flags update, N (bit 3) equals result bit 31 and Z (bit 2) is 1 exactly when the 32-bit result is zero.
- R8: For arithmetic and arithmetic compares with flag update, C (bit 1) is the adder carry-out; on subtract forms C=1 means no borrow occurred (3-5 gives C=0, 5-3 gives C=1).
- R9: For arithmetic and arithmetic compares with flag update, V (bit 0) is set exactly when the signed two's-complement result of the effective operation overflows 32 bits.
- R10: For logic, move and logic compares with flag update, C takes `shift_carry` and V keeps its `flags_in` value; a flag-setting move of zero gives Z=1, N=0.
- R11: A flag-setting add on the low words followed by an add-with-carry on the high words, using the first step's `flags_out` as `flags_in`, gives the correct 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Operation code (instruction bits 24:21) |
| set_flags | input | 1 | Flag update enable (instruction bit 20) |
| op_a | input | 32 | First operand from the register file |
| op_b | input | 32 | Second operand from the shifter or immediate path |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| shift_carry | input | 1 | Carry-out of the shifter |
| result | output | 32 | Computed value (also driven for compare codes) |
| result_we | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The hardest cases are the borrow-consuming forms at signed and unsigned boundaries, where the incoming carry decides both the borrow and whether overflow fires, and the 64-bit chain, where the second step depends on the flags produced by the first. Random stimulus draws operands heavily from 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF with random incoming flags, so every carry-consuming code meets both carry values at those edges. Directed sequences feed one step's flags output into the next step's flags input to cover carry propagation across word halves.

// File: rtl/dpalu_pkg.sv
// Package: shared opcode encoding and flag layout for the data-processing ALU.
// Assumes the opcode values match the instruction decoder field at bits 24:21.
package dpalu_pkg;

    typedef enum logic [3:0] {
        OPC_AND   = 4'h0,
        OPC_XOR   = 4'h1,
        OPC_SUB   = 4'h2,
        OPC_RSUB  = 4'h3,
        OPC_ADD   = 4'h4,
        OPC_ADDC  = 4'h5,
        OPC_SUBC  = 4'h6,
        OPC_RSUBC = 4'h7,
        OPC_TSTA  = 4'h8,
        OPC_TSTX  = 4'h9,
        OPC_CMPS  = 4'hA,
        OPC_CMPA  = 4'hB,
        OPC_OR    = 4'hC,
        OPC_MOVE  = 4'hD,
        OPC_CLR   = 4'hE,
        OPC_MOVN  = 4'hF
    } dp_opc_e;

    // Flag vector layout, MSB first: negative, zero, carry, overflow.
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } dp_flags_t;

    // Compare codes write no result and always update the flags.
    function automatic logic opc_is_compare(input logic [3:0] opc);
        return (opc[3:2] == 2'b10);
    endfunction

    // Codes whose result and C/V come from the adder.
    function automatic logic opc_is_arith(input logic [3:0] opc);
        return (opc[3:2] == 2'b01) || (opc == 4'h2) || (opc == 4'h3) ||
               (opc == 4'hA) || (opc == 4'hB);
    endfunction

endpackage

// File: rtl/dpalu_addsub.sv
// Module: shared adder for all add, subtract, reverse subtract and arithmetic
// compare codes. Subtraction is done as x + ~y + carry-in, so the carry-out
// already means "no borrow". Assumes codes outside the adder set are ignored
// by the caller.
module dpalu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);
    import dpalu_pkg::*;

    localparam int SW = WIDTH + 1;

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_ci;
    logic [SW-1:0]    full_sum;

    // Select addends and carry-in so every form reduces to one addition.
    always_comb begin
        add_x  = op_a;
        add_y  = op_b;
        add_ci = 1'b0;
        case (opcode)
            OPC_SUB, OPC_CMPS: begin
                add_y  = ~op_b;
                add_ci = 1'b1;
            end
            OPC_RSUB: begin
                add_x  = op_b;
                add_y  = ~op_a;
                add_ci = 1'b1;
            end
            OPC_ADDC: begin
                add_ci = carry_in;
            end
            OPC_SUBC: begin
                add_y  = ~op_b;
                add_ci = carry_in;
            end
            OPC_RSUBC: begin
                add_x  = op_b;
                add_y  = ~op_a;
                add_ci = carry_in;
            end
            default: begin
                add_ci = 1'b0;
            end
        endcase
    end

    // One carry chain one bit wider than the datapath.
    always_comb begin
        full_sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_ci};
    end

    // Expose sum, carry and signed overflow of the effective addition.
    always_comb begin
        sum       = full_sum[WIDTH-1:0];
        carry_out = full_sum[WIDTH];
        overflow  = (add_x[WIDTH-1] == add_y[WIDTH-1]) &&
                    (full_sum[WIDTH-1] != add_x[WIDTH-1]);
    end

endmodule

// File: rtl/dpalu_logic.sv
// Module: bitwise logic, move and move-inverted results, including the logic
// compare codes. Assumes the adder codes are routed elsewhere (output is zero).
module dpalu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       opcode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] value
);
    import dpalu_pkg::*;

    // Pick the bitwise function named by the opcode.
    always_comb begin
        case (opcode)
            OPC_AND, OPC_TSTA: value = op_a & op_b;
            OPC_XOR, OPC_TSTX: value = op_a ^ op_b;
            OPC_OR:            value = op_a | op_b;
            OPC_MOVE:          value = op_b;
            OPC_CLR:           value = op_a & ~op_b;
            OPC_MOVN:          value = ~op_b;
            default:           value = '0;
        endcase
    end

endmodule

// File: rtl/dpalu_flags.sv
// Module: next-flag generator. Chooses the carry and overflow source by
// operation class and holds the incoming flags when no update is requested.
// Assumes the caller marks compare codes as forced updates.
module dpalu_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    input  logic             is_arith,
    input  logic             force_update,
    input  logic             set_flags,
    input  logic [3:0]       flags_in,
    input  logic             add_carry,
    input  logic             add_overflow,
    input  logic             shift_carry,
    output logic [3:0]       flags_out
);
    import dpalu_pkg::*;

    dp_flags_t cur;
    dp_flags_t nxt;
    logic      do_update;

    // Decide whether this operation writes the flags.
    always_comb begin
        do_update = set_flags | force_update;
        cur       = dp_flags_t'(flags_in);
    end

    // Build the next flag set from the result and the chosen carry source.
    always_comb begin
        nxt = cur;
        if (do_update) begin
            nxt.n = value[WIDTH-1];
            nxt.z = (value == '0);
            if (is_arith) begin
                nxt.c = add_carry;
                nxt.v = add_overflow;
            end else begin
                nxt.c = shift_carry;
                nxt.v = cur.v;
            end
        end
        flags_out = nxt;
    end

endmodule

// File: rtl/dp_alu.sv
// Module: top of the data-processing ALU. Combinational: classifies the
// opcode, runs the adder and logic unit in parallel, selects the result and
// computes the next flags. Assumes operand B has already passed the shifter.
module dp_alu #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       opcode,
    input  logic             set_flags,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       flags_in,
    input  logic             shift_carry,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic [3:0]       flags_out
);
    import dpalu_pkg::*;

    logic             cls_arith;
    logic             cls_compare;
    logic [WIDTH-1:0] arith_value;
    logic             arith_carry;
    logic             arith_ovf;
    logic [WIDTH-1:0] logic_value;

    // Classify the opcode once for all consumers.
    always_comb begin
        cls_arith   = opc_is_arith(opcode);
        cls_compare = opc_is_compare(opcode);
    end

    dpalu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .opcode    (opcode),
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (flags_in[1]),
        .sum       (arith_value),
        .carry_out (arith_carry),
        .overflow  (arith_ovf)
    );

    dpalu_logic #(.WIDTH(WIDTH)) u_logic (
        .opcode (opcode),
        .op_a   (op_a),
        .op_b   (op_b),
        .value  (logic_value)
    );

    // Steer the result and gate the destination write.
    always_comb begin
        result    = cls_arith ? arith_value : logic_value;
        result_we = ~cls_compare;
    end

    dpalu_flags #(.WIDTH(WIDTH)) u_flags (
        .value        (result),
        .is_arith     (cls_arith),
        .force_update (cls_compare),
        .set_flags    (set_flags),
        .flags_in     (flags_in),
        .add_carry    (arith_carry),
        .add_overflow (arith_ovf),
        .shift_carry  (shift_carry),
        .flags_out    (flags_out)
    );

endmodule

// File: rtl/dpalu_checker.sv
// Module: property checker for dp_alu. The block has no clock, so the
// properties are immediate assertions evaluated whenever the ports settle.
module dpalu_checker #(
    parameter int WIDTH = 32
) (
    input logic [3:0]       opcode,
    input logic             set_flags,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       flags_in,
    input logic             shift_carry,
    input logic [WIDTH-1:0] result,
    input logic             result_we,
    input logic [3:0]       flags_out
);
    logic cmp_code;
    logic log_code;
    logic upd;

    // Port-level properties of the ALU.
    always_comb begin
        cmp_code = (opcode >= 4'h8) && (opcode <= 4'hB);
        log_code = (opcode == 4'h0) || (opcode == 4'h1) || (opcode == 4'h8) ||
                   (opcode == 4'h9) || (opcode >= 4'hC);
        upd      = set_flags || cmp_code;

        p_cmp_no_write_r4: assert (!cmp_code || !result_we)
            else $error("compare code wrote a result");
        p_write_enable_r5: assert (cmp_code || result_we)
            else $error("data code did not write");
        p_flags_hold_r6: assert (upd || (flags_out == flags_in))
            else $error("flags changed without update");
        p_nz_r7: assert (!upd || ((flags_out[3] == result[WIDTH-1]) &&
                                  (flags_out[2] == (result == '0))))
            else $error("N/Z do not match result");
        p_move_pass_r3: assert ((opcode != 4'hD) || (result == op_b))
            else $error("move did not pass operand B");
        p_logic_cv_r10: assert (!(upd && log_code) ||
                                ((flags_out[1] == shift_carry) &&
                                 (flags_out[0] == flags_in[0])))
            else $error("logic C/V source wrong");
        p_add_ovf_r9: assert ((opcode != 4'h4) || !set_flags ||
                              (flags_out[0] == ((op_a[WIDTH-1] == op_b[WIDTH-1]) &&
                                                (result[WIDTH-1] != op_a[WIDTH-1]))))
            else $error("add overflow flag wrong");
    end

endmodule

bind dp_alu dpalu_checker #(.WIDTH(WIDTH)) u_dpalu_checker (
    .opcode      (opcode),
    .set_flags   (set_flags),
    .op_a        (op_a),
    .op_b        (op_b),
    .flags_in    (flags_in),
    .shift_carry (shift_carry),
    .result      (result),
    .result_we   (result_we),
    .flags_out   (flags_out)
);

// File: tb/dp_alu_bench.sv
// Bench: directed corner cases plus seeded random vectors against a model.
module dp_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int N_RANDOM   = 4000;

    logic          clk = 1'b0;
    logic [3:0]    opcode = 4'h0;
    logic          set_flags = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [3:0]    flags_in = 4'h0;
    logic          shift_carry = 1'b0;
    logic [W-1:0]  result;
    logic          result_we;
    logic [3:0]    flags_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu #(.WIDTH(W)) u_dp_alu (
        .opcode      (opcode),
        .set_flags   (set_flags),
        .op_a        (op_a),
        .op_b        (op_b),
        .flags_in    (flags_in),
        .shift_carry (shift_carry),
        .result      (result),
        .result_we   (result_we),
        .flags_out   (flags_out)
    );

    // Reference model written from the requirements.
    function automatic void model(input logic [3:0] op, input logic s,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic [3:0] fi, input logic sc,
                                  output logic [31:0] r, output logic we,
                                  output logic [3:0] fo);
        longint ua = longint'({32'd0, a});
        longint ub = longint'({32'd0, b});
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint cin = longint'(fi[1]);
        longint us = 0;
        longint ss = 0;
        logic arith = 1'b1;
        logic cmp = (op >= 4'h8) && (op <= 4'hB);
        logic c_new;
        logic v_new;
        case (op)
            4'h4, 4'hB: begin us = ua + ub;       ss = sa + sb;       end
            4'h5:       begin us = ua + ub + cin; ss = sa + sb + cin; end
            4'h2, 4'hA: begin us = ua - ub;       ss = sa - sb;       end
            4'h6:       begin us = ua - ub - (1 - cin); ss = sa - sb - (1 - cin); end
            4'h3:       begin us = ub - ua;       ss = sb - sa;       end
            4'h7:       begin us = ub - ua - (1 - cin); ss = sb - sa - (1 - cin); end
            default:    arith = 1'b0;
        endcase
        case (op)
            4'h0, 4'h8: r = a & b;
            4'h1, 4'h9: r = a ^ b;
            4'hC:       r = a | b;
            4'hD:       r = b;
            4'hE:       r = a & ~b;
            4'hF:       r = ~b;
            default:    r = us[31:0];
        endcase
        // adds carry on >= 2^32; subtracts carry when no borrow (non-negative)
        if (op == 4'h4 || op == 4'h5 || op == 4'hB) c_new = (us >= 64'sd4294967296);
        else c_new = (us >= 0);
        v_new = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        we = !cmp;
        fo = fi;
        if (s || cmp) begin
            fo[3] = r[31];
            fo[2] = (r == 32'd0);
            fo[1] = arith ? c_new : sc;
            fo[0] = arith ? v_new : fi[0];
        end
    endfunction

    function automatic string class_tag(input logic [3:0] op, input logic s, input int what);
        logic cmp = (op >= 4'h8) && (op <= 4'hB);
        logic ar  = (op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB;
        if (what == 0) return ar ? "R1" : ((op == 4'hD || op == 4'hF) ? "R3" : "R2");
        if (what == 1) return cmp ? "R4" : "R5";
        if (cmp) return "R4";
        if (!s) return "R6";
        return ar ? "R9" : "R10";
    endfunction

    // Drive one vector at the falling edge, sample at the rising edge, compare.
    task automatic run_vec(input logic [3:0] op, input logic s, input logic [31:0] a,
                           input logic [31:0] b, input logic [3:0] fi, input logic sc,
                           input string tag);
        logic [31:0] er;
        logic        ewe;
        logic [3:0]  ef;
        @(negedge clk);
        opcode = op; set_flags = s; op_a = a; op_b = b; flags_in = fi; shift_carry = sc;
        model(op, s, a, b, fi, sc, er, ewe, ef);
        @(posedge clk);
        #1;
        n_checks++;
        if (ewe !== result_we) begin
            n_fails++;
            $display("FAIL %s op=%0h we actual=%b expected=%b", (tag != "") ? tag : class_tag(op, s, 1), op, result_we, ewe);
        end else if (ewe && (er !== result)) begin
            n_fails++;
            $display("FAIL %s op=%0h result actual=%h expected=%h", (tag != "") ? tag : class_tag(op, s, 0), op, result, er);
        end else if (ef !== flags_out) begin
            n_fails++;
            $display("FAIL %s op=%0h flags actual=%b expected=%b", (tag != "") ? tag : class_tag(op, s, 2), op, flags_out, ef);
        end
    endtask

    task automatic expect_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : stimulus
        logic [31:0] lo_sum;
        logic [31:0] hi_sum;
        logic [3:0]  chain_f;
        void'($urandom(32'd1357));

        // Idle all-zero vector: AND of zeros, flags held (R5, R6).
        @(posedge clk); #1;
        expect_val("R5", {63'd0, result_we}, 64'd1);
        expect_val("R6", {60'd0, flags_out}, 64'd0);

        // R8: 3-5 borrows (C=0), 5-3 does not (C=1).
        run_vec(4'h2, 1'b1, 32'd3, 32'd5, 4'b0000, 1'b0, "R8");
        expect_val("R8", {63'd0, flags_out[1]}, 64'd0);
        run_vec(4'h2, 1'b1, 32'd5, 32'd3, 4'b0000, 1'b0, "R8");
        expect_val("R8", {63'd0, flags_out[1]}, 64'd1);

        // R10: flag-setting move of zero, V held at 1, C from shifter.
        run_vec(4'hD, 1'b1, 32'h1234, 32'd0, 4'b1001, 1'b1, "R10");
        expect_val("R10", {60'd0, flags_out}, 64'b0111);

        // R9: signed overflow on add and subtract edges.
        run_vec(4'h4, 1'b1, 32'h7FFF_FFFF, 32'd1, 4'b0000, 1'b0, "R9");
        expect_val("R9", {63'd0, flags_out[0]}, 64'd1);
        run_vec(4'h2, 1'b1, 32'h8000_0000, 32'd1, 4'b0000, 1'b0, "R9");
        expect_val("R9", {63'd0, flags_out[0]}, 64'd1);
        run_vec(4'h7, 1'b1, 32'd1, 32'h8000_0000, 4'b0000, 1'b0, "R9");

        // R4: compare with set_flags low still updates, no write.
        run_vec(4'hA, 1'b0, 32'd7, 32'd7, 4'b0000, 1'b0, "R4");
        expect_val("R4", {60'd0, flags_out}, 64'b0110);
        run_vec(4'h8, 1'b0, 32'hF0, 32'h0F, 4'b0001, 1'b1, "R4");

        // R6: data op with set_flags low keeps flags.
        run_vec(4'h4, 1'b0, 32'hFFFF_FFFF, 32'd1, 4'b1011, 1'b0, "R6");
        expect_val("R6", {60'd0, flags_out}, 64'b1011);

        // R7: negative result sets N.
        run_vec(4'hF, 1'b1, 32'd0, 32'd0, 4'b0000, 1'b0, "R7");
        expect_val("R7", {60'd0, flags_out}, 64'b1000);

        // R11: 64-bit chain 0x00000001_FFFFFFFF + 0x00000002_00000001.
        @(negedge clk);
        opcode = 4'h4; set_flags = 1'b1; op_a = 32'hFFFF_FFFF; op_b = 32'h0000_0001;
        flags_in = 4'b0000; shift_carry = 1'b0;
        @(posedge clk); #1;
        lo_sum = result; chain_f = flags_out;
        @(negedge clk);
        opcode = 4'h5; set_flags = 1'b0; op_a = 32'h0000_0001; op_b = 32'h0000_0002;
        flags_in = chain_f;
        @(posedge clk); #1;
        hi_sum = result;
        expect_val("R11", {hi_sum, lo_sum}, 64'h0000_0004_0000_0000);

        // R1 R2 R3: seeded random sweep over every opcode with boundary-heavy operands.
        for (int i = 0; i < N_RANDOM; i++) begin
            run_vec(4'($urandom % 16), 1'($urandom % 2), pick_operand(), pick_operand(),
                    4'($urandom % 16), 1'($urandom % 2), "");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule